// File: doc/BRIEF.md
# Multi-Format Audio Serial Frame Transmitter

The block turns parallel audio words into a synchronous serial stream. It is always the clock and frame master: it divides the system clock down to a bit clock, produces a frame sync, and shifts one data bit out per bit-clock period. Four frame layouts are supported: I2S, PCM with a one-bit sync pulse, PCM with a half-frame sync, and left-justified. They differ in sync polarity, sync length, data start offset and the bit-clock edge on which outputs change.

Software-side logic feeds words through a valid/ready write port that holds exactly one word. The word moves into the shifter when a new word slot begins. If no word is waiting at that moment, the block raises a sticky underrun flag. It then sends zeros and keeps the clocks running until it is disabled. Format, word length, words per frame, bit order, divider and clock gating are captured only while the enable is low.

Top module: `audio_frame_tx`

## Requirements
- R1: Configuration is captured only while `enable` is low. The block runs only with divider 1..4095, word length 2..32 and words per frame 1..16. Otherwise, and whenever `enable` is low, `bclk_o`, `fsync_o` and `sdata_o` stay 0.
- R2: One bit slot lasts 2×`clk_div` system clock cycles, so two rising edges of a continuous `bclk_o` are that far apart.
- R3: The first bit slot starts on the first clock edge with `enable` high. Slot 0 outputs are visible one cycle after `enable` rises.
- R4: `fmt`=0 (I2S) always uses two words per frame, whatever `frame_words` says. `fsync_o` is 0 for the first `word_bits` slots and 1 for the rest. Data is delayed by one slot, so a frame's last bit leaves in slot 0 of the following frame, and slot 0 of the very first frame carries 0.
- R5: `fmt`=1 (short-sync PCM) drives `fsync_o` high in slot 0 only, and data starts in slot 0. In both PCM formats (`fmt`=1,2) the outputs change while `bclk_o` rises and are sampled on its falling edge. In the other formats the outputs change while it falls and are sampled on its rising edge.
- R6: `fmt`=2 (long-sync PCM) and `fmt`=3 (left-justified) drive `fsync_o` high for the first floor(words×bits/2) slots, and data starts in slot 0.
- R7: A frame is 2×ceil(words×bits/2) slots long. When words×bits is odd, the trailing extra slot carries 0.
- R8: With `lsb_first`=0 each word leaves MSB first (bit `word_bits`−1 down to bit 0 of `wr_data`). With `lsb_first`=1 it leaves LSB first.
- R9: With `gate_clk`=1, `bclk_o` toggles only during slots that carry data bits. With `gate_clk`=0 it runs in every slot.
- R10: `wr_ready` is 1 exactly when the holding register is empty. A write offered while it is full is dropped. The held word is consumed when the next word's first bit is sent.
- R11: If the holding register is empty when a word must start, `underrun_o` goes to 1 and stays 1 until `enable` is low. From then on `sdata_o` is 0 while `bclk_o` and `fsync_o` keep running.
- R12: Changing configuration inputs while `enable` is high has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the transmitter; low clears underrun and captures configuration |
| fmt | input | 2 | Frame layout: 0 I2S, 1 short-sync PCM, 2 long-sync PCM, 3 left-justified |
| word_bits | input | 6 | Bits per word, 2..32 |
| frame_words | input | 5 | Words per frame, 1..16 (ignored for I2S) |
| lsb_first | input | 1 | 1 sends each word LSB first |
| clk_div | input | 13 | Bit clock divider, 1..4095 |
| gate_clk | input | 1 | 1 stops the bit clock outside data slots |
| wr_valid | input | 1 | Offer a word |
| wr_data | input | 32 | Word, right-aligned |
| wr_ready | output | 1 | Holding register empty |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
The bench targets the I2S one-slot data delay. An off-by-one design would shift every bit by a slot or drop the last bit that spills into the next frame. Odd frame lengths are exercised so that a design missing the padding slot drifts by one bit every frame. A gated clock with a padding slot would expose a spurious clock pulse. The bench also checks that a write into a full holding register is dropped rather than overwriting the held word. It checks that underrun silences the data line without stopping the clocks, and that an illegal divider or word length leaves every line quiet.

// File: rtl/aft_pkg.sv
// Package: shared limits, derived widths, frame layout codes and the
// captured configuration record for the audio frame transmitter.
package aft_pkg;
    localparam int MAX_BITS  = 32;
    localparam int MAX_WORDS = 16;
    localparam int DIV_MAX   = 4095;
    localparam int BITS_W    = $clog2(MAX_BITS + 1);
    localparam int WORDS_W   = $clog2(MAX_WORDS + 1);
    localparam int DIV_W     = $clog2(DIV_MAX + 2);
    localparam int SLOT_W    = $clog2(MAX_BITS * MAX_WORDS + 1) + 1;

    typedef enum logic [1:0] {
        FMT_I2S       = 2'd0,
        FMT_PCM_SHORT = 2'd1,
        FMT_PCM_LONG  = 2'd2,
        FMT_LEFT      = 2'd3
    } fmt_e;

    typedef struct packed {
        fmt_e               fmt;
        logic [BITS_W-1:0]  bits;
        logic [WORDS_W-1:0] words;
        logic               lsb_first;
        logic [DIV_W-1:0]   div;
        logic               gate;
    } cfg_t;

    // Legal ranges for divider, word length and words per frame.
    function automatic logic cfg_legal(input cfg_t c);
        return (c.div >= DIV_W'(1)) && (c.div <= DIV_W'(DIV_MAX)) &&
               (c.bits >= BITS_W'(2)) && (c.bits <= BITS_W'(MAX_BITS)) &&
               (c.words >= WORDS_W'(1)) && (c.words <= WORDS_W'(MAX_WORDS));
    endfunction
endpackage

// File: rtl/aft_clkgen.sv
// Bit clock generator. Divides clk by 2*div into a phase signal and emits
// a one-cycle slot tick at each falling phase edge. The first tick lands
// on the first cycle with run high. Assumes div is nonzero while run is high.
module aft_clkgen
    import aft_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             phase,
    output logic             run_q
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0) && phase;

    // Half-period down counter and phase toggle; idles one step before a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            phase <= 1'b1;
            run_q <= 1'b0;
        end else begin
            run_q <= 1'b1;
            if (cnt_q == '0) begin
                cnt_q <= div - DIV_W'(1);
                phase <= ~phase;
            end else begin
                cnt_q <= cnt_q - DIV_W'(1);
            end
        end
    end

    // R2: slot ticks are never back to back
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/aft_framer.sv
// Frame slot sequencer. Counts bit slots within a frame. At each tick it
// registers the frame sync level and a data-window flag for the slot being
// entered. It also reports combinationally whether the current slot carries
// data. Assumes period, nb and bits are stable while run is high.
module aft_framer
    import aft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  fmt_e              fmt,
    input  logic [SLOT_W-1:0] bits,
    input  logic [SLOT_W-1:0] nb,
    input  logic [SLOT_W-1:0] period,
    output logic              active,
    output logic              fsync_q,
    output logic              win_q
);
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] data_idx;
    logic              primed_q;
    logic              delayed;
    logic              fs_next;

    assign delayed = (fmt == FMT_I2S);

    // Data bit position of this slot, with the one-slot I2S delay wrapped.
    always_comb begin
        if (delayed && slot_q == '0) data_idx = period - SLOT_W'(1);
        else if (delayed)            data_idx = slot_q - SLOT_W'(1);
        else                         data_idx = slot_q;
    end

    assign active = (data_idx < nb) && (primed_q || !(delayed && slot_q == '0));

    // Frame sync level per layout for the slot being entered.
    always_comb begin
        unique case (fmt)
            FMT_I2S:       fs_next = (slot_q >= bits);
            FMT_PCM_SHORT: fs_next = (slot_q == '0);
            default:       fs_next = (slot_q < (nb >> 1));
        endcase
    end

    // Slot counter, sync and data-window registers, advanced once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot_q   <= '0;
            primed_q <= 1'b0;
            fsync_q  <= 1'b0;
            win_q    <= 1'b0;
        end else if (tick) begin
            fsync_q  <= fs_next;
            win_q    <= active;
            primed_q <= 1'b1;
            slot_q   <= (slot_q == period - SLOT_W'(1)) ? '0 : slot_q + SLOT_W'(1);
        end
    end

    // R7: the slot counter never reaches the frame period
    a_r7_slot_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (slot_q < period));
endmodule

// File: rtl/aft_serializer.sv
// Word path. Holds one written word. At the first data slot of each word it
// moves that word into the working register, then puts out one bit per data
// slot in the selected order. Flags a sticky underrun when no word is waiting
// and then sends zeros. Assumes bits is in 2..DATA_W while run is high.
module aft_serializer
    import aft_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              run,
    input  logic              tick,
    input  logic              active,
    input  logic [BITS_W-1:0] bits,
    input  logic              lsb_first,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              sdata_q,
    output logic              underrun_q
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] hold_q;
    logic              hold_full;
    logic [DATA_W-1:0] word_q;
    logic [BITS_W-1:0] dbit_q;
    logic [DATA_W-1:0] cur_word;
    logic [IDX_W-1:0]  bit_idx;
    logic              load;

    assign wr_ready = !hold_full;
    assign load     = tick && active && (dbit_q == '0);
    assign cur_word = (dbit_q != '0) ? word_q : (hold_full ? hold_q : '0);
    assign bit_idx  = lsb_first ? dbit_q[IDX_W-1:0]
                                : IDX_W'(bits - BITS_W'(1) - dbit_q);

    // Holding register: accept when empty, release on a word load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else begin
            if (load && hold_full) hold_full <= 1'b0;
            if (wr_valid && !hold_full) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
        end
    end

    // Bit output and bit-within-word counter, stepped on data slots only.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            word_q  <= '0;
            dbit_q  <= '0;
            sdata_q <= 1'b0;
        end else if (tick) begin
            if (active) begin
                sdata_q <= underrun_q ? 1'b0 : cur_word[bit_idx];
                word_q  <= cur_word;
                dbit_q  <= (dbit_q == bits - BITS_W'(1)) ? '0 : dbit_q + BITS_W'(1);
            end else begin
                sdata_q <= 1'b0;
            end
        end
    end

    // Sticky underrun flag, cleared only by dropping enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)         underrun_q <= 1'b0;
        else if (load && !hold_full)   underrun_q <= 1'b1;
    end

    // R10: a write offered while full leaves the held word untouched
    a_r10_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && hold_full) |=> $stable(hold_q));
    // R11: underrun persists while enabled
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun_q && enable) |=> underrun_q);
    // R11: data line silent during underrun
    a_r11_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_q |-> !sdata_q);
endmodule

// File: rtl/audio_frame_tx.sv
// Audio frame transmitter top. Captures configuration while disabled,
// derives the frame geometry, and joins the clock generator, slot
// sequencer and word path. Bit clock polarity and gating are applied here.
// Assumes a single clock domain; all outputs are registered or built from registers.
module audio_frame_tx
    import aft_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         fmt,
    input  logic [BITS_W-1:0]  word_bits,
    input  logic [WORDS_W-1:0] frame_words,
    input  logic               lsb_first,
    input  logic [DIV_W-1:0]   clk_div,
    input  logic               gate_clk,
    input  logic               wr_valid,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               wr_ready,
    output logic               bclk_o,
    output logic               fsync_o,
    output logic               sdata_o,
    output logic               underrun_o
);
    cfg_t              cfg_q;
    logic              run;
    logic              tick, phase, run_q;
    logic              active, win_q;
    logic              inv;
    logic [SLOT_W-1:0] n_eff, nb, half_len, period, bits_ext;

    // Capture configuration only while the transmitter is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (!enable) begin
            cfg_q.fmt       <= fmt_e'(fmt);
            cfg_q.bits      <= word_bits;
            cfg_q.words     <= frame_words;
            cfg_q.lsb_first <= lsb_first;
            cfg_q.div       <= clk_div;
            cfg_q.gate      <= gate_clk;
        end
    end

    // Frame geometry from the captured configuration.
    always_comb begin
        bits_ext = SLOT_W'(cfg_q.bits);
        n_eff    = (cfg_q.fmt == FMT_I2S) ? SLOT_W'(2) : SLOT_W'(cfg_q.words);
        nb       = n_eff * bits_ext;
        half_len = (nb + SLOT_W'(1)) >> 1;
        period   = half_len << 1;
    end

    assign run = enable && cfg_legal(cfg_q);
    assign inv = (cfg_q.fmt == FMT_PCM_SHORT) || (cfg_q.fmt == FMT_PCM_LONG);

    aft_clkgen u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg_q.div),
        .tick  (tick),
        .phase (phase),
        .run_q (run_q)
    );

    aft_framer u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .fmt     (cfg_q.fmt),
        .bits    (bits_ext),
        .nb      (nb),
        .period  (period),
        .active  (active),
        .fsync_q (fsync_o),
        .win_q   (win_q)
    );

    aft_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .run        (run),
        .tick       (tick),
        .active     (active),
        .bits       (cfg_q.bits),
        .lsb_first  (cfg_q.lsb_first),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .sdata_q    (sdata_o),
        .underrun_q (underrun_o)
    );

    assign bclk_o = run_q && (!cfg_q.gate || win_q) && (phase ^ inv);

    // R1: every line is quiet once disabled
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bclk_o && !fsync_o && !sdata_o));
endmodule

// File: tb/audio_frame_tx_test.sv
`timescale 1ns/1ps
module audio_frame_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  fmt_in = 2'd0;
    logic [5:0]  bits_in = 6'd8;
    logic [4:0]  words_in = 5'd2;
    logic        lsb_in = 1'b0;
    logic [12:0] div_in = 13'd2;
    logic        gate_in = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, bclk_o, fsync_o, sdata_o, underrun_o;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_cnt = 0;
    int unsigned seed = 32'h1234_5678;
    bit [31:0]   wlist[$];
    logic [1:0]  exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge bclk_o) edge_cnt++;

    audio_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fmt(fmt_in),
        .word_bits(bits_in), .frame_words(words_in), .lsb_first(lsb_in),
        .clk_div(div_in), .gate_clk(gate_in), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_ready(wr_ready), .bclk_o(bclk_o),
        .fsync_o(fsync_o), .sdata_o(sdata_o), .underrun_o(underrun_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic data_bit(input int g, input int b, input int lsb);
        int k = g % b;
        bit [31:0] w = wlist[g / b];
        return w[lsb ? k : b - 1 - k];
    endfunction

    // Driver side of the scoreboard: expected {fsync,data} per sampled slot.
    task automatic build(input int f_i, input int b, input int n, input int lsb,
                         input int gate, input int frames);
        int neff = (f_i == 0) ? 2 : n;
        int nb   = neff * b;
        int per  = 2 * ((nb + 1) / 2);
        exp_q.delete();
        wlist.delete();
        for (int i = 0; i < frames * neff; i++) begin
            bit [63:0] mask = (64'd1 << b) - 64'd1;
            seed = seed * 32'd1103515245 + 32'd12345;
            wlist.push_back(32'(({32'd0, seed} ^ {32'd0, seed >> 7}) & mask));
        end
        for (int f = 0; f < frames; f++) begin
            for (int s = 0; s < per; s++) begin
                logic fs;
                int   g;
                case (f_i)
                    0:       fs = (s >= b);
                    1:       fs = (s == 0);
                    default: fs = (s < nb / 2);
                endcase
                if (f_i == 0) g = (s == 0) ? f * nb - 1 : f * nb + s - 1;
                else          g = (s < nb) ? f * nb + s : -1;
                if (!(gate != 0 && g < 0))
                    exp_q.push_back({fs, (g < 0) ? 1'b0 : data_bit(g, b, lsb)});
            end
        end
        if (f_i == 0) exp_q.push_back({1'b0, data_bit(frames * nb - 1, b, lsb)});
    endtask

    task automatic write_word(input bit [31:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Monitor side: samples at the mid-slot bit clock edge and compares.
    task automatic monitor(input bit inv, input string tag);
        int idx = 0;
        while (exp_q.size() > 0) begin
            logic [1:0] e;
            if (inv) @(negedge bclk_o);
            else     @(posedge bclk_o);
            #1;
            e = exp_q.pop_front();
            check({fsync_o, sdata_o} == e, tag, $sformatf("slot %0d {fsync,data}", idx),
                  int'({fsync_o, sdata_o}), int'(e));
            idx++;
        end
    endtask

    task automatic run_scn(input int f_i, input int b, input int n, input int lsb,
                           input int div, input int gate, input int frames,
                           input string tag);
        int per;
        int e0;
        int bad;
        @(negedge clk);
        enable = 1'b0;
        fmt_in = 2'(f_i); bits_in = 6'(b); words_in = 5'(n);
        lsb_in = 1'(lsb); div_in = 13'(div); gate_in = 1'(gate);
        repeat (2) @(negedge clk);
        build(f_i, b, n, lsb, gate, frames);
        per = 2 * (((f_i == 0 ? 2 : n) * b + 1) / 2);
        write_word(wlist[0]);
        if (f_i == 1) begin
            // R10: holding register full, offered word must be dropped
            check(wr_ready == 1'b0, "R10", "wr_ready while full", int'(wr_ready), 0);
            wr_valid = 1'b1;
            wr_data  = 32'hFFFF_FFFF;
            @(negedge clk);
            wr_valid = 1'b0;
        end
        @(negedge clk);
        enable = 1'b1;
        fork
            begin
                for (int i = 1; i < wlist.size(); i++) write_word(wlist[i]);
            end
            monitor(f_i == 1 || f_i == 2, tag);
            begin
                @(posedge clk);
                #1;
                if (f_i == 1) begin
                    // R3: slot 0 sync and inverted clock one cycle after enable
                    check(fsync_o == 1'b1, "R3", "fsync after first edge", int'(fsync_o), 1);
                    check(bclk_o == 1'b1, "R5", "PCM bclk high at slot start", int'(bclk_o), 1);
                end
                if (f_i == 0) begin
                    // R12: disturb configuration inputs while running
                    fmt_in = 2'd1; bits_in = 6'd7; words_in = 5'd3; lsb_in = 1'b1;
                end
            end
            begin
                if (div == 3) begin
                    realtime t1, t2;
                    @(posedge bclk_o); t1 = $realtime;
                    @(posedge bclk_o); t2 = $realtime;
                    check((t2 - t1) == 30.0, "R2", "bclk period ns", int'(t2 - t1), 30);
                end
            end
        join
        // R11: underrun after the supplied words run out
        while (!underrun_o) @(negedge clk);
        check(underrun_o == 1'b1, "R11", "underrun raised", int'(underrun_o), 1);
        e0 = edge_cnt;
        bad = 0;
        repeat (per * 2 * div * 2) begin
            @(negedge clk);
            if (sdata_o !== 1'b0 || underrun_o !== 1'b1) bad++;
        end
        check(bad == 0, "R11", "data silent and flag held", bad, 0);
        check(edge_cnt - e0 >= 2, "R11", "bit clock keeps running", edge_cnt - e0, 2);
        enable = 1'b0;
        @(posedge clk);
        #1;
        check(underrun_o == 1'b0, "R11", "underrun cleared by disable", int'(underrun_o), 0);
        check({bclk_o, fsync_o, sdata_o} == 3'b000, "R1", "quiet after disable",
              int'({bclk_o, fsync_o, sdata_o}), 0);
    endtask

    task automatic bad_cfg(input int b, input int n, input int div, input string what);
        int e0;
        int hi = 0;
        @(negedge clk);
        enable = 1'b0;
        fmt_in = 2'd3; bits_in = 6'(b); words_in = 5'(n); div_in = 13'(div); gate_in = 1'b0;
        repeat (2) @(negedge clk);
        e0 = edge_cnt;
        enable = 1'b1;
        repeat (60) begin
            @(negedge clk);
            if (fsync_o || sdata_o || bclk_o) hi++;
        end
        check(edge_cnt == e0 && hi == 0, "R1", what, edge_cnt - e0 + hi, 0);
        enable = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check({bclk_o, fsync_o, sdata_o, underrun_o} == 4'b0000, "R1", "reset outputs",
              int'({bclk_o, fsync_o, sdata_o, underrun_o}), 0);
        check(wr_ready == 1'b1, "R10", "reset wr_ready", int'(wr_ready), 1);

        run_scn(0, 16, 5, 0, 2, 0, 2, "R4 R12 R8");
        run_scn(1, 8, 3, 1, 1, 0, 2, "R5 R8 R10");
        run_scn(2, 5, 1, 0, 2, 0, 3, "R6 R7 R5");
        run_scn(3, 3, 3, 0, 2, 1, 2, "R9 R6 R7");
        run_scn(3, 32, 2, 0, 3, 0, 1, "R6 R8 R2");

        bad_cfg(8, 2, 0, "divider zero");
        bad_cfg(8, 2, 4096, "divider 4096");
        bad_cfg(1, 2, 2, "word length 1");
        bad_cfg(8, 0, 2, "zero words");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule